// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic stage of a small accumulator-style processor core. It is purely combinational. It takes an 8-bit accumulator operand `a`, a second operand `b`, a 4-bit operation code and the current carry, half-carry and zero flags. From these it computes the next 8-bit result and the next value of each flag. Flag storage lives outside the block. When an operation leaves a flag unchanged, the block simply returns the incoming flag value.

Add, subtract, increment and decrement all go through one shared 9-bit adder. Subtraction is formed as `a + ~b + 1`, so after a subtract the carry reads as "no borrow". The half-carry flag is the carry out of bit 3 of that same adder. The logic path is a per-bit four-way selector: pass, OR, AND or XOR. Bit set and bit clear reuse the OR and AND legs with a one-hot mask. A small rotator handles rotate-left and rotate-right through carry.

The block has no states: its only "transition" is the input-to-output path, which settles within the same cycle. The operation code plays the role of the selector that a state would normally provide.

Top module: `acc_alu`

## Requirements
- R1: Code 0 (add): `y = (a + b) mod 256`, `c_out` is bit 8 of the 9-bit sum, and `hc_out` is 1 exactly when `a[3:0] + b[3:0] > 15`.
- R2: Code 1 (subtract): `y = (a - b) mod 256`, `c_out` is 1 exactly when `a >= b` (no borrow), and `hc_out` is 1 exactly when `a[3:0] >= b[3:0]`.
- R3: Codes 2 (increment) and 3 (decrement): `y = a + 1` or `y = a - 1` mod 256, and `c_out`/`hc_out` equal `c_in`/`hc_in`.
- R4: For codes 0 to 11, `z_out` is 1 exactly when `y` is 0x00.
- R5: Codes 4 (AND), 5 (OR), 6 (XOR) and 7 (pass `a`) give the bitwise result, with `c_out`/`hc_out` equal to `c_in`/`hc_in`.
- R6: Code 8 sets bit `b[2:0]` of `a` and code 9 clears bit `b[2:0]` of `a`; `b[7:3]` has no effect, and carry and half-carry pass through unchanged.
- R7: Code 10 (rotate left through carry): `y = {a[6:0], c_in}` and `c_out = a[7]`; `hc_out = hc_in`.
- R8: Code 11 (rotate right through carry): `y = {c_in, a[7:1]}` and `c_out = a[0]`; `hc_out = hc_in`.
- R9: Codes 12 to 15 are reserved: `y = a` and all three flag outputs equal their inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | Accumulator operand |
| b | input | 8 | Second operand; `b[2:0]` is the bit index for set/clear |
| op | input | 4 | Operation code |
| c_in | input | 1 | Current carry flag |
| hc_in | input | 1 | Current half-carry flag |
| z_in | input | 1 | Current zero flag |
| y | output | 8 | Result |
| c_out | output | 1 | Next carry flag |
| hc_out | output | 1 | Next half-carry flag |
| z_out | output | 1 | Next zero flag |

## Verification
Every result and flag is due zero cycles after its inputs change, because no register lies on any path. The bench therefore drives a vector and samples one nanosecond later, before the next vector is applied. It covers add and subtract exhaustively over all operand pairs, with fixed-seed random vectors over every code and directed corner cases. Each sampled value is compared with a bench function written directly from the requirements.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_PASS = 4'd7,
        OP_BSET = 4'd8,
        OP_BCLR = 4'd9,
        OP_RLC  = 4'd10,
        OP_RRC  = 4'd11,
        OP_RSV0 = 4'd12,
        OP_RSV1 = 4'd13,
        OP_RSV2 = 4'd14,
        OP_RSV3 = 4'd15
    } alu_op_e;

    localparam logic [1:0] LSEL_PASS = 2'd0;
    localparam logic [1:0] LSEL_OR   = 2'd1;
    localparam logic [1:0] LSEL_AND  = 2'd2;
    localparam logic [1:0] LSEL_XOR  = 2'd3;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] yv,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hcout
);
    localparam int HW = W - NIB;

    logic [NIB:0] lo;
    logic [HW:0]  hi;

    // Split at the nibble boundary so the half-carry is a real adder tap.
    always_comb begin
        lo    = {1'b0, x[NIB-1:0]} + {1'b0, yv[NIB-1:0]} + {{NIB{1'b0}}, cin};
        hi    = {1'b0, x[W-1:NIB]} + {1'b0, yv[W-1:NIB]} + {{HW{1'b0}}, lo[NIB]};
        sum   = {hi[HW-1:0], lo[NIB-1:0]};
        cout  = hi[HW];
        hcout = lo[NIB];
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] m,
    input  logic [1:0]   sel,
    output logic [W-1:0] r
);
    // One four-way selector per bit: pass, OR, AND, XOR.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign r[i] = sel[1] ? (sel[0] ? (a[i] ^ m[i]) : (a[i] & m[i]))
                             : (sel[0] ? (a[i] | m[i]) : a[i]);
    end
endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] rl,
    output logic         rl_c,
    output logic [W-1:0] rr,
    output logic         rr_c
);
    assign rl   = {a[W-2:0], cin};
    assign rl_c = a[W-1];
    assign rr   = {cin, a[W-1:1]};
    assign rr_c = a[0];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   op,
    input  logic         c_in,
    input  logic         hc_in,
    input  logic         z_in,
    output logic [W-1:0] y,
    output logic         c_out,
    output logic         hc_out,
    output logic         z_out
);
    localparam int IDXW = $clog2(W);

    alu_op_e       op_e;
    logic [W-1:0]  bit_mask;
    logic [W-1:0]  add_b;
    logic          add_ci;
    logic [W-1:0]  add_sum;
    logic          add_co;
    logic          add_hc;
    logic [1:0]    lsel;
    logic [W-1:0]  lop;
    logic [W-1:0]  lres;
    logic [W-1:0]  rl_y;
    logic [W-1:0]  rr_y;
    logic          rl_c;
    logic          rr_c;

    assign op_e     = alu_op_e'(op);
    assign bit_mask = W'(1) << b[IDXW-1:0];

    // Operand steering for the shared adder and the logic selector.
    always_comb begin
        add_b  = b;
        add_ci = 1'b0;
        lsel   = LSEL_PASS;
        lop    = b;
        unique case (op_e)
            OP_SUB:  begin add_b = ~b;        add_ci = 1'b1; end
            OP_INC:  begin add_b = '0;        add_ci = 1'b1; end
            OP_DEC:  begin add_b = '1;        add_ci = 1'b0; end
            OP_AND:  lsel = LSEL_AND;
            OP_OR:   lsel = LSEL_OR;
            OP_XOR:  lsel = LSEL_XOR;
            OP_BSET: begin lsel = LSEL_OR;  lop = bit_mask;  end
            OP_BCLR: begin lsel = LSEL_AND; lop = ~bit_mask; end
            default: ;
        endcase
    end

    acc_alu_adder #(.W(W), .NIB(NIB)) u_adder (
        .x(a), .yv(add_b), .cin(add_ci),
        .sum(add_sum), .cout(add_co), .hcout(add_hc)
    );

    acc_alu_logic #(.W(W)) u_logic (
        .a(a), .m(lop), .sel(lsel), .r(lres)
    );

    acc_alu_rotate #(.W(W)) u_rot (
        .a(a), .cin(c_in),
        .rl(rl_y), .rl_c(rl_c), .rr(rr_y), .rr_c(rr_c)
    );

    // Result and flag selection.
    always_comb begin
        y      = a;
        c_out  = c_in;
        hc_out = hc_in;
        z_out  = z_in;
        unique case (op_e)
            OP_ADD, OP_SUB: begin
                y      = add_sum;
                c_out  = add_co;
                hc_out = add_hc;
                z_out  = (add_sum == '0);
            end
            OP_INC, OP_DEC: begin
                y     = add_sum;
                z_out = (add_sum == '0);
            end
            OP_AND, OP_OR, OP_XOR, OP_PASS, OP_BSET, OP_BCLR: begin
                y     = lres;
                z_out = (lres == '0);
            end
            OP_RLC: begin
                y     = rl_y;
                c_out = rl_c;
                z_out = (rl_y == '0);
            end
            OP_RRC: begin
                y     = rr_y;
                c_out = rr_c;
                z_out = (rr_y == '0);
            end
            default: ;
        endcase
    end

    // Port-level checks next to the selection logic.
    always_comb begin
        if (op_e == OP_SUB) begin
            assert_sub_noborrow_R2: assert (c_out == (a >= b))
                else $error("subtract carry does not match no-borrow");
        end
        if (op_e == OP_INC || op_e == OP_DEC) begin
            assert_incdec_keep_R3: assert (c_out == c_in && hc_out == hc_in)
                else $error("inc/dec altered carry or half-carry");
        end
        if (op_e == OP_BSET) begin
            assert_bset_bit_R6: assert (y[b[IDXW-1:0]] == 1'b1)
                else $error("bit set left target bit clear");
        end
        if (op_e == OP_BCLR) begin
            assert_bclr_bit_R6: assert (y[b[IDXW-1:0]] == 1'b0)
                else $error("bit clear left target bit set");
        end
        if (op_e == OP_RLC) begin
            assert_rlc_carry_R7: assert (c_out == a[W-1] && y[0] == c_in)
                else $error("rotate left carry path wrong");
        end
        if (op_e == OP_RRC) begin
            assert_rrc_carry_R8: assert (c_out == a[0] && y[W-1] == c_in)
                else $error("rotate right carry path wrong");
        end
        if (op[3:2] == 2'b11) begin
            assert_reserved_pass_R9: assert (y == a && c_out == c_in
                                             && hc_out == hc_in && z_out == z_in)
                else $error("reserved code changed state");
        end
    end
endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a = '0, b = '0;
    logic [3:0] op = '0;
    logic       c_in = 1'b0, hc_in = 1'b0, z_in = 1'b0;
    logic [7:0] y;
    logic       c_out, hc_out, z_out;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    acc_alu dut_i (
        .a(a), .b(b), .op(op), .c_in(c_in), .hc_in(hc_in), .z_in(z_in),
        .y(y), .c_out(c_out), .hc_out(hc_out), .z_out(z_out)
    );

    // Expected {y, c, hc, z} from the requirements.
    function automatic logic [10:0] model(input logic [3:0] o, input logic [7:0] x,
                                          input logic [7:0] v, input logic c,
                                          input logic h, input logic z);
        logic [8:0] s;
        logic [7:0] r;
        logic       nc, nh, nz;
        r = x; nc = c; nh = h; nz = z;
        case (o)
            4'd0: begin s = {1'b0, x} + {1'b0, v}; r = s[7:0]; nc = s[8];
                        nh = ({1'b0, x[3:0]} + {1'b0, v[3:0]}) > 5'd15; end
            4'd1: begin r = x - v; nc = (x >= v); nh = (x[3:0] >= v[3:0]); end
            4'd2: r = x + 8'd1;
            4'd3: r = x - 8'd1;
            4'd4: r = x & v;
            4'd5: r = x | v;
            4'd6: r = x ^ v;
            4'd7: r = x;
            4'd8: begin r = x; r[v[2:0]] = 1'b1; end
            4'd9: begin r = x; r[v[2:0]] = 1'b0; end
            4'd10: begin r = {x[6:0], c}; nc = x[7]; end
            4'd11: begin r = {c, x[7:1]}; nc = x[0]; end
            default: ;
        endcase
        if (o < 4'd12) nz = (r == 8'h00);
        return {r, nc, nh, nz};
    endfunction

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4, 4'd5, 4'd6, 4'd7: return "R5";
            4'd8, 4'd9: return "R6";
            4'd10: return "R7";
            4'd11: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input string req, input logic [3:0] o, input logic [7:0] x,
                         input logic [7:0] v, input logic c, input logic h,
                         input logic z);
        logic [10:0] exp, act;
        op = o; a = x; b = v; c_in = c; hc_in = h; z_in = z;
        #1;
        exp = model(o, x, v, c, h, z);
        act = {y, c_out, hc_out, z_out};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h: got y=%h c=%b hc=%b z=%b, want y=%h c=%b hc=%b z=%b",
                     req, o, x, v, act[10:3], act[2], act[1], act[0],
                     exp[10:3], exp[2], exp[1], exp[0]);
        end
        // Zero flag cross-check for every updating code.
        if (o < 4'd12) begin
            n_run++;
            if (z_out !== (y == 8'h00)) begin
                n_fail++;
                $display("FAIL R4 op=%0d: z_out=%b y=%h, want z_out=%b",
                         o, z_out, y, (y == 8'h00));
            end
        end
        #1;
    endtask

    initial begin
        #750000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset-state style check: all-zero inputs, add gives zero result.
        apply("R1", 4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);

        // Directed corners.
        apply("R1", 4'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 1'b0);  // 0x00, c=1, hc=1
        apply("R1", 4'd0, 8'h08, 8'h08, 1'b1, 1'b0, 1'b1);  // nibble carry only
        apply("R2", 4'd1, 8'h00, 8'h01, 1'b1, 1'b1, 1'b1);  // borrow, c=0
        apply("R2", 4'd1, 8'h80, 8'h80, 1'b0, 1'b0, 1'b0);  // zero, no borrow
        apply("R2", 4'd1, 8'h10, 8'h01, 1'b0, 1'b1, 1'b0);  // nibble borrow
        apply("R3", 4'd2, 8'hFF, 8'h55, 1'b0, 1'b1, 1'b0);  // wraps to zero, flags kept
        apply("R3", 4'd3, 8'h00, 8'hAA, 1'b1, 1'b0, 1'b1);  // wraps to FF
        apply("R5", 4'd6, 8'h5A, 8'h5A, 1'b1, 1'b1, 1'b0);  // XOR to zero
        apply("R6", 4'd8, 8'h00, 8'hFB, 1'b0, 1'b0, 1'b1);  // set bit 3, high b ignored
        apply("R6", 4'd9, 8'hFF, 8'h07, 1'b1, 1'b1, 1'b1);  // clear bit 7
        apply("R6", 4'd9, 8'h01, 8'hF8, 1'b0, 1'b0, 1'b0);  // clear bit 0 -> zero
        apply("R7", 4'd10, 8'h80, 8'h00, 1'b1, 1'b0, 1'b0); // 0x01, c=1
        apply("R7", 4'd10, 8'h80, 8'h00, 1'b0, 1'b1, 1'b0); // 0x00, c=1, z=1
        apply("R8", 4'd11, 8'h01, 8'h00, 1'b0, 1'b1, 1'b0); // 0x00, c=1
        apply("R8", 4'd11, 8'h02, 8'h00, 1'b1, 1'b0, 1'b1); // 0x81, c=0
        apply("R9", 4'd13, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0); // nothing changes
        apply("R9", 4'd15, 8'h3C, 8'h3C, 1'b0, 1'b1, 1'b1);

        // Exhaustive operand pairs through the shared adder.
        for (int i = 0; i < 65536; i++)
            apply("R1", 4'd0, i[15:8], i[7:0], i[0], i[1], i[2]);
        for (int i = 0; i < 65536; i++)
            apply("R2", 4'd1, i[15:8], i[7:0], i[3], i[4], i[5]);

        // Random vectors across every code.
        for (int k = 0; k < 4000; k++) begin
            logic [3:0] ro;
            logic [7:0] ra, rb;
            logic [2:0] rf;
            ro = 4'($urandom);
            ra = 8'($urandom);
            rb = 8'($urandom);
            rf = 3'($urandom);
            apply(req_of(ro), ro, ra, rb, rf[0], rf[1], rf[2]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule